// File: doc/BRIEF.md
# Read QoS Latency Timeout Tracker

This block holds quality-of-service state for every slot of an eight-entry arbitration queue in a memory controller. When a read address is accepted into a slot, a four-bit index is cut out of the read ID. Its position in the ID is set by a three-bit shift value. The index selects one of sixteen per-ID settings, each made of an enable, a minimum-latency bit and a 12-bit maximum-latency count. An enabled read loads the count and decrements it once per cycle. When the count is zero, the entry shows a maximum-latency timeout. A read marked for minimum latency shows a minimum-latency timeout at once. A per-ID override bit forces that flag regardless of the enable.

Write entries are tracked for validity only and never carry QoS values of their own. Hazard detection lies outside the block and arrives as a dependency matrix. Each timed-out entry pushes the same kind of timeout onto the entries it depends on, so that its predecessors get promoted ahead of it. The downstream arbiter uses the flags, and ranks minimum-latency timeouts above maximum-latency ones.

Top module: `qos_latency_tracker`

## Requirements
- R1: After reset, every entry is invalid and all timeout outputs are low.
- R2: The settings index is rdId[idShift+3:idShift], with ID bits above the ID width read as zero. For example, ID 0x5A with shift 2 gives index 6.
- R3: Suppose an accepted read's index has its enable set and its minimum-latency bit set. Then minTimeout for that slot is high from the first cycle after the accept.
- R4: An enabled read loads its maximum-latency count L and decrements it once per cycle. maxTimeout is high from the L-th cycle after the accept, so L=0 gives a timeout in the first cycle. The count then stays at zero and the flag stays high while the entry is valid.
- R5: A read whose index has its enable clear shows no timeout of either kind, whatever its minimum-latency bit and count are, unless R6 applies.
- R6: If overrideVec[index] is high on the accept cycle, minTimeout for that slot is high from the next cycle, even when the enable is clear.
- R7: A write allocation makes the slot valid with both timeouts low, and no own timeout ever appears on it.
- R8: Bit depMatrix[i*8+j] set means that entry i depends on entry j. If entry i shows a timeout of a given kind and j is valid, then j shows that same kind from the next cycle on. This moves one hop per cycle, and the flag stays set on j until j is retired or reallocated.
- R9: Retiring a slot clears its valid bit, flags and count from the next cycle. Reallocating a slot discards any timeout that was forced onto it earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdAccept | input | 1 | Read address accepted into rdSlot this cycle |
| rdId | input | IdWidth | Read ID of the accepted read |
| rdSlot | input | 3 | Queue slot for the read |
| wrAccept | input | 1 | Write accepted into wrSlot this cycle |
| wrSlot | input | 3 | Queue slot for the write |
| retire | input | 1 | Invalidate retireSlot |
| retireSlot | input | 3 | Slot being invalidated |
| idShift | input | 3 | Position of the four-bit index inside the ID |
| cfgEnable | input | 16 | Per-index QoS enable |
| cfgMinLat | input | 16 | Per-index minimum-latency bit |
| cfgMaxLat | input | 192 | Per-index 12-bit maximum-latency count, index k at bits [12k+11:12k] |
| overrideVec | input | 16 | Per-index forced minimum-latency timeout |
| depMatrix | input | 64 | Dependency bits, [i*8+j] = entry i depends on entry j |
| entryValid | output | 8 | Slot occupied |
| minTimeout | output | 8 | Minimum-latency timeout per slot |
| maxTimeout | output | 8 | Maximum-latency timeout per slot |

## Verification
The assertions assume that a read and a write are never allocated to the same slot in one cycle. They also assume that a retire never targets a slot that is allocated in that same cycle. The stimulus drives at most one allocation or retire per task call, and it always uses distinct slots, so both conditions hold throughout. The dependency matrix only changes on falling edges, between allocations. Because of this, the one-hop-per-cycle propagation can be counted exactly from the cycle the source entry times out.

// File: rtl/qos_pkg.sv
`timescale 1ns/1ps
package qos_pkg;
  localparam int SLOT_W  = 3;
  localparam int ENTRIES = 1 << SLOT_W;
  localparam int CNT_W   = 12;
  localparam int IDX_W   = 4;
  localparam int CFG_NUM = 1 << IDX_W;
  localparam int SHIFT_W = 3;

  typedef struct packed {
    logic              rdGo;
    logic [SLOT_W-1:0] rdSlot;
    logic              wrGo;
    logic [SLOT_W-1:0] wrSlot;
    logic              retGo;
    logic [SLOT_W-1:0] retSlot;
    logic              qosOn;
    logic              minOn;
    logic [CNT_W-1:0]  maxVal;
  } qos_strobe_t;
endpackage

// File: rtl/qos_ctrl.sv
`timescale 1ns/1ps
module qos_ctrl
  import qos_pkg::*;
#(
  parameter int IdWidth = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rdAccept,
  input  logic [IdWidth-1:0]       rdId,
  input  logic [SLOT_W-1:0]        rdSlot,
  input  logic                     wrAccept,
  input  logic [SLOT_W-1:0]        wrSlot,
  input  logic                     retire,
  input  logic [SLOT_W-1:0]        retireSlot,
  input  logic [SHIFT_W-1:0]       idShift,
  input  logic [CFG_NUM-1:0]       cfgEnable,
  input  logic [CFG_NUM-1:0]       cfgMinLat,
  input  logic [CFG_NUM*CNT_W-1:0] cfgMaxLat,
  input  logic [CFG_NUM-1:0]       overrideVec,
  output qos_strobe_t              strb
);
  localparam int PAD_W = IdWidth + (1 << SHIFT_W);

  logic [PAD_W-1:0] idPad;
  logic [PAD_W-1:0] idShifted;
  logic [IDX_W-1:0] cfgIdx;
  logic             selEn;
  logic [CNT_W-1:0] selMax;

  // Sliding four-bit window over the read ID picks the settings index
  always_comb begin
    idPad = '0;
    idPad[IdWidth-1:0] = rdId;
    idShifted = idPad >> idShift;
    cfgIdx = idShifted[IDX_W-1:0];
    selEn  = cfgEnable[cfgIdx];
    selMax = cfgMaxLat[cfgIdx*CNT_W +: CNT_W];
  end

  always_comb begin
    strb.rdGo    = rdAccept;
    strb.rdSlot  = rdSlot;
    strb.wrGo    = wrAccept;
    strb.wrSlot  = wrSlot;
    strb.retGo   = retire;
    strb.retSlot = retireSlot;
    strb.qosOn   = selEn;
    strb.minOn   = (selEn & cfgMinLat[cfgIdx]) | overrideVec[cfgIdx];
    strb.maxVal  = selEn ? selMax : '0;
  end

  // Input assumptions: one allocation per slot per cycle, no retire of a fresh slot
  assert_rd_wr_slots_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdAccept && wrAccept) |-> (rdSlot != wrSlot));
  assert_retire_rd_slot_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdAccept && retire) |-> (rdSlot != retireSlot));
  assert_retire_wr_slot_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrAccept && retire) |-> (wrSlot != retireSlot));
endmodule

// File: rtl/qos_entries.sv
`timescale 1ns/1ps
module qos_entries
  import qos_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  qos_strobe_t                strb,
  input  logic [ENTRIES*ENTRIES-1:0] depMatrix,
  output logic [ENTRIES-1:0]         entryValid,
  output logic [ENTRIES-1:0]         minTimeout,
  output logic [ENTRIES-1:0]         maxTimeout
);
  logic [ENTRIES-1:0] valid, qosEn, minOwn, minForced, maxForced;
  logic [ENTRIES-1:0] allocRd, allocWr, clr, pushMin, pushMax;
  logic [CNT_W-1:0]   cnt [ENTRIES];

  // Dependency push: an entry's timeout lands on what it waits for, one hop per cycle
  always_comb begin
    pushMin = '0;
    pushMax = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (minTimeout[i] && depMatrix[i*ENTRIES+j]) pushMin[j] = 1'b1;
        if (maxTimeout[i] && depMatrix[i*ENTRIES+j]) pushMax[j] = 1'b1;
      end
    end
  end

  assign entryValid = valid;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    assign allocRd[e] = strb.rdGo  && (strb.rdSlot  == SLOT_W'(e));
    assign allocWr[e] = strb.wrGo  && (strb.wrSlot  == SLOT_W'(e));
    assign clr[e]     = strb.retGo && (strb.retSlot == SLOT_W'(e));
    assign minTimeout[e] = valid[e] & (minOwn[e] | minForced[e]);
    assign maxTimeout[e] = valid[e] & ((qosEn[e] & (cnt[e] == '0)) | maxForced[e]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        valid[e] <= 1'b0; qosEn[e] <= 1'b0; minOwn[e] <= 1'b0;
        minForced[e] <= 1'b0; maxForced[e] <= 1'b0; cnt[e] <= '0;
      end else if (allocRd[e]) begin
        valid[e] <= 1'b1; qosEn[e] <= strb.qosOn; minOwn[e] <= strb.minOn;
        minForced[e] <= 1'b0; maxForced[e] <= 1'b0; cnt[e] <= strb.maxVal;
      end else if (allocWr[e] || clr[e]) begin
        valid[e] <= allocWr[e]; qosEn[e] <= 1'b0; minOwn[e] <= 1'b0;
        minForced[e] <= 1'b0; maxForced[e] <= 1'b0; cnt[e] <= '0;
      end else if (valid[e]) begin
        if (qosEn[e] && (cnt[e] != '0)) cnt[e] <= cnt[e] - 1'b1;
        if (pushMin[e]) minForced[e] <= 1'b1;
        if (pushMax[e]) maxForced[e] <= 1'b1;
      end
    end

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rstN)
      (valid[e] && qosEn[e] && cnt[e] != '0 && !allocRd[e] && !allocWr[e] && !clr[e])
      |=> (cnt[e] == $past(cnt[e]) - 1'b1));
    assert_count_floor_R4: assert property (@(posedge clk) disable iff (!rstN)
      (maxTimeout[e] && !allocRd[e] && !allocWr[e] && !clr[e]) |=> maxTimeout[e]);
    assert_override_load_R6: assert property (@(posedge clk) disable iff (!rstN)
      (allocRd[e] && strb.minOn) |=> minTimeout[e]);
    assert_write_clean_R7: assert property (@(posedge clk) disable iff (!rstN)
      allocWr[e] |=> (entryValid[e] && !minTimeout[e] && !maxTimeout[e]));
    assert_retire_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
      (clr[e] && !allocRd[e] && !allocWr[e]) |=> (!entryValid[e] && !minTimeout[e] && !maxTimeout[e]));

    for (genvar s = 0; s < ENTRIES; s++) begin : g_src
      assert_push_min_R8: assert property (@(posedge clk) disable iff (!rstN)
        (minTimeout[s] && depMatrix[s*ENTRIES+e] && valid[e] && !allocRd[e] && !allocWr[e] && !clr[e])
        |=> minTimeout[e]);
      assert_push_max_R8: assert property (@(posedge clk) disable iff (!rstN)
        (maxTimeout[s] && depMatrix[s*ENTRIES+e] && valid[e] && !allocRd[e] && !allocWr[e] && !clr[e])
        |=> maxTimeout[e]);
    end
  end
endmodule

// File: rtl/qos_latency_tracker.sv
`timescale 1ns/1ps
module qos_latency_tracker
  import qos_pkg::*;
#(
  parameter int IdWidth = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rdAccept,
  input  logic [IdWidth-1:0]         rdId,
  input  logic [SLOT_W-1:0]          rdSlot,
  input  logic                       wrAccept,
  input  logic [SLOT_W-1:0]          wrSlot,
  input  logic                       retire,
  input  logic [SLOT_W-1:0]          retireSlot,
  input  logic [SHIFT_W-1:0]         idShift,
  input  logic [CFG_NUM-1:0]         cfgEnable,
  input  logic [CFG_NUM-1:0]         cfgMinLat,
  input  logic [CFG_NUM*CNT_W-1:0]   cfgMaxLat,
  input  logic [CFG_NUM-1:0]         overrideVec,
  input  logic [ENTRIES*ENTRIES-1:0] depMatrix,
  output logic [ENTRIES-1:0]         entryValid,
  output logic [ENTRIES-1:0]         minTimeout,
  output logic [ENTRIES-1:0]         maxTimeout
);
  qos_strobe_t strb;

  qos_ctrl #(.IdWidth(IdWidth)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .rdAccept(rdAccept), .rdId(rdId), .rdSlot(rdSlot),
    .wrAccept(wrAccept), .wrSlot(wrSlot),
    .retire(retire), .retireSlot(retireSlot),
    .idShift(idShift), .cfgEnable(cfgEnable), .cfgMinLat(cfgMinLat),
    .cfgMaxLat(cfgMaxLat), .overrideVec(overrideVec),
    .strb(strb)
  );

  qos_entries u_entries (
    .clk(clk), .rstN(rstN), .strb(strb), .depMatrix(depMatrix),
    .entryValid(entryValid), .minTimeout(minTimeout), .maxTimeout(maxTimeout)
  );
endmodule

// File: tb/qos_latency_tracker_bench.sv
`timescale 1ns/1ps
module qos_latency_tracker_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         rdAccept = 1'b0;
  logic [11:0]  rdId = '0;
  logic [2:0]   rdSlot = '0;
  logic         wrAccept = 1'b0;
  logic [2:0]   wrSlot = '0;
  logic         retire = 1'b0;
  logic [2:0]   retireSlot = '0;
  logic [2:0]   idShift = '0;
  logic [15:0]  cfgEnable = '0;
  logic [15:0]  cfgMinLat = '0;
  logic [191:0] cfgMaxLat = '0;
  logic [15:0]  overrideVec = '0;
  logic [63:0]  depMatrix = '0;
  logic [7:0]   entryValid, minTimeout, maxTimeout;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  qos_latency_tracker u_qos_latency_tracker (
    .clk(clk), .rstN(rstN), .rdAccept(rdAccept), .rdId(rdId), .rdSlot(rdSlot),
    .wrAccept(wrAccept), .wrSlot(wrSlot), .retire(retire), .retireSlot(retireSlot),
    .idShift(idShift), .cfgEnable(cfgEnable), .cfgMinLat(cfgMinLat),
    .cfgMaxLat(cfgMaxLat), .overrideVec(overrideVec), .depMatrix(depMatrix),
    .entryValid(entryValid), .minTimeout(minTimeout), .maxTimeout(maxTimeout)
  );

  task automatic chk(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic allocRead(input int slot, input logic [11:0] id);
    @(negedge clk);
    rdAccept = 1'b1; rdSlot = 3'(slot); rdId = id;
    @(negedge clk);
    rdAccept = 1'b0;
  endtask

  task automatic allocWrite(input int slot);
    @(negedge clk);
    wrAccept = 1'b1; wrSlot = 3'(slot);
    @(negedge clk);
    wrAccept = 1'b0;
  endtask

  task automatic retireOne(input int slot);
    @(negedge clk);
    retire = 1'b1; retireSlot = 3'(slot);
    @(negedge clk);
    retire = 1'b0;
  endtask

  task automatic setMax(input int idx, input int val);
    cfgMaxLat[idx*12 +: 12] = 12'(val);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int first;
    int idx;
    logic [11:0] ids [4];
    ids[0] = 12'h05A; ids[1] = 12'h0A5; ids[2] = 12'h3C7; ids[3] = 12'hF0F;

    for (int k = 0; k < 16; k++) setMax(k, k + 2);
    cfgEnable = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", int'(entryValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid", int'(entryValid), 0);
    chk("R1 min", int'(minTimeout), 0);
    chk("R1 max", int'(maxTimeout), 0);

    // R2 and R4: sweep all shifts over several IDs, L = index + 2
    for (int sh = 0; sh < 8; sh++) begin
      for (int t = 0; t < 4; t++) begin
        idShift = 3'(sh);
        idx = (int'(ids[t]) >> sh) & 15;
        allocRead(0, ids[t]);
        chk("R3 no min when bit clear", int'(minTimeout[0]), 0);
        first = -1;
        for (int c = 0; c < 25; c++) begin
          if (first < 0 && maxTimeout[0]) first = c;
          @(negedge clk);
        end
        chk("R2 R4 timeout cycle", first, idx + 2);
        chk("R4 saturated flag", int'(maxTimeout[0]), 1);
        retireOne(0);
      end
    end

    // R2 worked example: 0x5A with shift 2 -> index 6, count 8
    idShift = 3'd2;
    allocRead(1, 12'h05A);
    first = -1;
    for (int c = 0; c < 12; c++) begin
      if (first < 0 && maxTimeout[1]) first = c;
      @(negedge clk);
    end
    chk("R2 example index 6", first, 8);
    retireOne(1);
    idShift = 3'd0;

    // R4 zero count times out at once
    setMax(5, 0);
    allocRead(2, 12'h005);
    chk("R4 zero count immediate", int'(maxTimeout[2]), 1);
    retireOne(2);

    // R3 minimum-latency bit with enable
    cfgMinLat[4] = 1'b1;
    allocRead(2, 12'h004);
    chk("R3 min timeout", int'(minTimeout[2]), 1);
    retireOne(2);

    // R5 disabled index: no timeouts at all
    cfgEnable[3] = 1'b0; cfgMinLat[3] = 1'b1; setMax(3, 0);
    allocRead(3, 12'h003);
    first = 0;
    for (int c = 0; c < 30; c++) begin
      if (minTimeout[3] || maxTimeout[3]) first = 1;
      @(negedge clk);
    end
    chk("R5 disabled stays quiet", first, 0);
    chk("R5 entry valid", int'(entryValid[3]), 1);
    retireOne(3);

    // R6 override on disabled index
    overrideVec[3] = 1'b1;
    allocRead(3, 12'h003);
    overrideVec[3] = 1'b0;
    chk("R6 override min", int'(minTimeout[3]), 1);
    repeat (10) @(negedge clk);
    chk("R6 no max on disabled", int'(maxTimeout[3]), 0);
    retireOne(3);

    // R7 write entry
    allocWrite(2);
    first = 0;
    for (int c = 0; c < 20; c++) begin
      if (minTimeout[2] || maxTimeout[2]) first = 1;
      @(negedge clk);
    end
    chk("R7 write valid", int'(entryValid[2]), 1);
    chk("R7 write no own timeout", first, 0);
    retireOne(2);

    // R8 min chain 0 -> 1 -> 2
    allocWrite(1);
    allocWrite(2);
    depMatrix[0*8+1] = 1'b1;
    depMatrix[1*8+2] = 1'b1;
    allocRead(0, 12'h004);
    chk("R8 hop0 src", int'(minTimeout[0]), 1);
    chk("R8 hop0 mid", int'(minTimeout[1]), 0);
    @(negedge clk);
    chk("R8 hop1 mid", int'(minTimeout[1]), 1);
    chk("R8 hop1 end", int'(minTimeout[2]), 0);
    @(negedge clk);
    chk("R8 hop2 end", int'(minTimeout[2]), 1);
    chk("R8 kind kept", int'(maxTimeout[2]), 0);
    retireOne(0);
    chk("R8 sticky after source gone", int'(minTimeout[1]), 1);

    // R9 retire clears, reallocation drops forced state
    retireOne(2);
    chk("R9 retired valid", int'(entryValid[2]), 0);
    chk("R9 retired min", int'(minTimeout[2]), 0);
    depMatrix = '0;
    allocWrite(1);
    chk("R9 realloc drops forced", int'(minTimeout[1]), 0);
    retireOne(1);

    // R8 max chain 3 -> 5, L = 2 (index 0)
    allocWrite(5);
    depMatrix[3*8+5] = 1'b1;
    allocRead(3, 12'h000);
    chk("R8 max c0 src", int'(maxTimeout[3]), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R8 max c2 src", int'(maxTimeout[3]), 1);
    chk("R8 max c2 dep", int'(maxTimeout[5]), 0);
    @(negedge clk);
    chk("R8 max c3 dep", int'(maxTimeout[5]), 1);
    chk("R8 max no min", int'(minTimeout[5]), 0);
    depMatrix = '0;
    retireOne(3);
    retireOne(5);
    chk("R9 all clear", int'(entryValid), 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule